// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through Queue Chain

This block builds one deep queue from a series of identical first-word-fall-through stages that all run on a single clock. The ready flag on one stage's output serves directly as the write strobe of the next stage. The ready flag on the next stage's input serves directly as the read strobe of the previous stage. No logic sits between stages, and the chain holds the sum of the stage depths. A word written into an empty chain travels to the far end without any read request. A slot freed at the far end of a full chain travels back toward the input one stage per clock.

The two flags are active low. `out_rdy_n` low means that `rd_data` holds the head word. `in_rdy_n` low means that a write will be taken. The two enables are also active low. A read is taken on a rising edge where both `rd_en_n` and `out_rdy_n` are low. A write is taken on a rising edge where both `wr_en_n` and `in_rdy_n` are low.

Each stage holds a small RAM and a head register, and is run by a three-state machine:
- ST_IDLE: empty. A write moves the stage to ST_FETCH.
- ST_FETCH: the RAM holds data and the head register is empty. The stage always moves to ST_SHOW on the next clock.
- ST_SHOW: the head register holds a word.
  - A read with words still in the RAM stays in ST_SHOW and reloads the head register.
  - A read with an empty RAM and a write in the same cycle goes to ST_FETCH.
  - A read with an empty RAM and no write goes to ST_IDLE.

Top module: `fwft_chain`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the chain empties. After that, `out_rdy_n` is 1 and `in_rdy_n` is 0.
- R2: While `out_rdy_n` is 0, `rd_data` shows the oldest stored word with no read needed. The word and the flag stay unchanged over every edge where `rd_en_n` is 1.
- R3: Words leave in the order they were accepted, with their values intact, under any pattern of enables.
- R4: With no reads, exactly STAGES*STAGE_DEPTH writes are accepted. `in_rdy_n` then stays 1.
- R5: In an empty chain, a write is taken at edge E. `out_rdy_n` first reads 0 after edge E+2*STAGES-1, with `rd_en_n` held at 1 throughout.
- R6: In a full, idle chain, a read is taken at edge E. `in_rdy_n` first reads 0 after edge E+STAGES-1.
- R7: A write presented while `in_rdy_n` is 1 is dropped. It never shows up at the output and changes no flag.
- R8: A read presented while `out_rdy_n` is 1 is dropped. The chain stays empty and the next word written is the first word out.
- R9: With a full chain and `rd_en_n` held at 0, reads are taken on STAGES*STAGE_DEPTH consecutive edges with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; it also moves words between stages |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | DATA_W | Word to store |
| in_rdy_n | output | 1 | Low when a write will be taken |
| rd_en_n | input | 1 | Read strobe, active low |
| rd_data | output | DATA_W | Head word (falls through without a read) |
| out_rdy_n | output | 1 | Low when `rd_data` holds a valid word |

## Verification
A write at the input and a read at the output can land on the same edge. Inside one stage, a push and a pop can also coincide. The hardest case is a stage in ST_SHOW whose RAM is empty: it must drop its head word and take in the next one on the same clock. Random phases with different write and read densities make these collisions happen across every stage boundary. A scoreboard queue then judges every word that leaves the chain by value and by order. A full drain with the read strobe held low shows that coincident transfers never open a gap.

// File: rtl/fwft_chain_pkg.sv
`timescale 1ns/1ps
package fwft_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHOW  = 2'd2
    } stage_state_e;

    // address width for a storage of d entries, never below one bit
    function automatic int unsigned addr_w(input int unsigned d);
        return (d > 1) ? $clog2(d) : 1;
    endfunction

endpackage

// File: rtl/chain_ptr.sv
`timescale 1ns/1ps
module chain_ptr #(
    parameter int unsigned LIMIT = 3,
    parameter int unsigned PW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/chain_ram.sv
`timescale 1ns/1ps
module chain_ram #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned AW    = 2,
    parameter int unsigned DW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fwft_stage.sv
`timescale 1ns/1ps
module fwft_stage
    import fwft_chain_pkg::*;
#(
    parameter int unsigned STAGE_DEPTH = 4,
    parameter int unsigned DW          = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    output logic          ir_n,
    input  logic          ren_n,
    output logic [DW-1:0] dout,
    output logic          or_n
);
    localparam int unsigned RAM_DEPTH = STAGE_DEPTH - 1;
    localparam int unsigned AW        = addr_w(RAM_DEPTH);
    localparam int unsigned CW        = $clog2(RAM_DEPTH + 1);
    localparam logic [CW-1:0] RAM_FULL = CW'(RAM_DEPTH);

    stage_state_e  state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          ir_n_q, ir_n_n;
    logic [DW-1:0] head_q;
    logic [DW-1:0] ram_q;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_pop, ram_rd;

    // accepted strobes
    assign do_wr  = !wen_n && !ir_n_q;
    assign do_pop = !ren_n && (state_q == ST_SHOW);
    // the head register reloads from storage on a fetch or on a pop with words left
    assign ram_rd = (state_q == ST_FETCH) || (do_pop && (cnt_q != '0));

    chain_ram #(.DEPTH(RAM_DEPTH), .AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_ptr),
        .rdata (ram_q)
    );

    chain_ptr #(.LIMIT(RAM_DEPTH), .PW(AW)) u_wptr (
        .clk (clk),
        .rst (rst),
        .adv (do_wr),
        .ptr (wr_ptr)
    );

    chain_ptr #(.LIMIT(RAM_DEPTH), .PW(AW)) u_rptr (
        .clk (clk),
        .rst (rst),
        .adv (ram_rd),
        .ptr (rd_ptr)
    );

    // next-state and flag computation
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_wr) state_n = ST_FETCH;
            end
            ST_FETCH: begin
                state_n = ST_SHOW;
            end
            ST_SHOW: begin
                if (do_pop) begin
                    if (cnt_q != '0) state_n = ST_SHOW;
                    else if (do_wr)  state_n = ST_FETCH;
                    else             state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        cnt_n  = cnt_q + CW'(do_wr) - CW'(ram_rd);
        // full only when storage is full and the head register is occupied
        ir_n_n = (cnt_n == RAM_FULL) && (state_n == ST_SHOW);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ir_n_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            ir_n_q  <= ir_n_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else if (ram_rd) begin
            head_q <= ram_q;
        end
    end

    // outputs
    always_comb begin
        or_n = (state_q != ST_SHOW);
        ir_n = ir_n_q;
        dout = head_q;
    end
endmodule

// File: rtl/fwft_chain.sv
`timescale 1ns/1ps
module fwft_chain #(
    parameter int unsigned STAGES      = 3,
    parameter int unsigned STAGE_DEPTH = 4,
    parameter int unsigned DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_rdy_n,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy_n
);
    // link k feeds stage k; link STAGES is the read side
    logic [DATA_W-1:0] link_d [STAGES+1];
    logic [STAGES:0]   link_v_n;
    logic [STAGES:0]   link_r_n;

    assign link_d[0]        = wr_data;
    assign link_v_n[0]      = wr_en_n;
    assign link_r_n[STAGES] = rd_en_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        fwft_stage #(.STAGE_DEPTH(STAGE_DEPTH), .DW(DATA_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .wen_n (link_v_n[k]),
            .din   (link_d[k]),
            .ir_n  (link_r_n[k]),
            .ren_n (link_r_n[k+1]),
            .dout  (link_d[k+1]),
            .or_n  (link_v_n[k+1])
        );
    end

    assign in_rdy_n  = link_r_n[0];
    assign rd_data   = link_d[STAGES];
    assign out_rdy_n = link_v_n[STAGES];
endmodule

// File: rtl/fwft_chain_chk.sv
`timescale 1ns/1ps
module fwft_chain_chk #(
    parameter int unsigned STAGES      = 3,
    parameter int unsigned STAGE_DEPTH = 4,
    parameter int unsigned DATA_W      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_n,
    input logic              in_rdy_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              out_rdy_n
);
    localparam int unsigned TOTAL = STAGES * STAGE_DEPTH;
    localparam int unsigned CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] CAP = CW'(TOTAL);

    logic          wacc, racc;
    logic [CW-1:0] fill_q;

    assign wacc = !wr_en_n && !in_rdy_n;
    assign racc = !rd_en_n && !out_rdy_n;

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill_q + CW'(wacc) - CW'(racc);
    end

    p_reset_flags_r1: assert property (@(posedge clk)
        rst |=> (out_rdy_n && !in_rdy_n));

    p_hold_head_r2: assert property (@(posedge clk) disable iff (rst)
        (!out_rdy_n && rd_en_n) |=> (!out_rdy_n && $stable(rd_data)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_q == CAP) |-> in_rdy_n);

    p_cap_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CAP);

    p_full_closed_r7: assert property (@(posedge clk) disable iff (rst)
        ((fill_q == CAP) && rd_en_n) |=> in_rdy_n);

    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_q == '0) |-> out_rdy_n);
endmodule

bind fwft_chain fwft_chain_chk #(
    .STAGES(STAGES), .STAGE_DEPTH(STAGE_DEPTH), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_n   (wr_en_n),
    .in_rdy_n  (in_rdy_n),
    .rd_en_n   (rd_en_n),
    .rd_data   (rd_data),
    .out_rdy_n (out_rdy_n)
);

// File: tb/fwft_chain_tb.sv
`timescale 1ns/1ps
module fwft_chain_tb;
    localparam int DW = 16, SD = 4, NA = 3, NB = 2;
    localparam int TOT_A = NA * SD, TOT_B = NB * SD;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic rst = 1'b1;
    logic a_wen_n = 1'b1, a_ren_n = 1'b1, a_ir_n, a_or_n;
    logic [DW-1:0] a_wd = '0, a_rd;
    logic b_wen_n = 1'b1, b_ren_n = 1'b1, b_ir_n, b_or_n;
    logic [DW-1:0] b_wd = '0, b_rd;

    fwft_chain #(.STAGES(NA), .STAGE_DEPTH(SD), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en_n(a_wen_n), .wr_data(a_wd), .in_rdy_n(a_ir_n),
        .rd_en_n(a_ren_n), .rd_data(a_rd), .out_rdy_n(a_or_n));

    fwft_chain #(.STAGES(NB), .STAGE_DEPTH(SD), .DATA_W(DW)) u_dut_n2 (
        .clk(clk), .rst(rst), .wr_en_n(b_wen_n), .wr_data(b_wd), .in_rdy_n(b_ir_n),
        .rd_en_n(b_ren_n), .rd_data(b_rd), .out_rdy_n(b_or_n));

    int n_chk = 0, n_bad = 0, acc_a = 0, acc_b = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] seq = 16'h0100;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: a read is taken on the coming edge when both flags are low
    always @(negedge clk) begin
        logic [DW-1:0] e;
        if (!rst && !a_ren_n && !a_or_n) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 word with empty scoreboard", int'(a_rd), -1);
            end else begin
                e = exp_q.pop_front();
                check(a_rd == e, "R3 order/value", int'(a_rd), int'(e));
            end
        end
    end

    // driver: one cycle, inputs set just after the edge
    task automatic step_a(input bit w, input bit r, input logic [DW-1:0] d);
        a_wen_n = !w; a_wd = d; a_ren_n = !r;
        if (w && !a_ir_n) begin
            exp_q.push_back(d);
            acc_a++;
        end
        @(posedge clk); #1;
    endtask

    task automatic step_b(input bit w, input bit r);
        b_wen_n = !w; b_ren_n = !r; b_wd = seq; seq++;
        if (w && !b_ir_n) acc_b++;
        @(posedge clk); #1;
    endtask

    task automatic fill_a(output int got);
        int base = acc_a;
        repeat (8 * TOT_A + 40) begin
            step_a(1'b1, 1'b0, seq); seq++;
        end
        a_wen_n = 1'b1;
        got = acc_a - base;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int k, got, n;
        logic [DW-1:0] d0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state on both chains
        check(a_or_n && !a_ir_n, "R1 reset flags N=3", {a_or_n, a_ir_n}, 2);
        check(b_or_n && !b_ir_n, "R1 reset flags N=2", {b_or_n, b_ir_n}, 2);

        // R5: ripple-down latency, N=2
        step_b(1'b1, 1'b0);
        b_wen_n = 1'b1; k = 0;
        while (b_or_n && k < 100) begin k++; @(posedge clk); #1; end
        check(k == 2*NB-1, "R5 ripple latency N=2", k, 2*NB-1);
        // R4: capacity of N=2 chain
        repeat (8 * TOT_B + 40) step_b(1'b1, 1'b0);
        b_wen_n = 1'b1;
        check(acc_b == TOT_B, "R4 capacity N=2", acc_b, TOT_B);
        // R6: bubble-up latency, N=2
        step_b(1'b0, 1'b1);
        b_ren_n = 1'b1; k = 0;
        while (b_ir_n && k < 100) begin k++; @(posedge clk); #1; end
        check(k == NB-1, "R6 bubble latency N=2", k, NB-1);

        // R8: reads on an empty chain are dropped
        for (int i = 0; i < 3; i++) begin
            step_a(1'b0, 1'b1, '0);
            check(a_or_n == 1'b1, "R8 empty read ignored", a_or_n, 1);
        end
        a_ren_n = 1'b1;

        // R5: ripple-down latency, N=3 (word then read out and compared)
        step_a(1'b1, 1'b0, 16'h00A5);
        a_wen_n = 1'b1; k = 0;
        while (a_or_n && k < 100) begin k++; @(posedge clk); #1; end
        check(k == 2*NA-1, "R5 ripple latency N=3", k, 2*NA-1);
        check(a_rd == 16'h00A5, "R8 first word after dropped reads", int'(a_rd), 16'h00A5);
        step_a(1'b0, 1'b1, '0);
        a_ren_n = 1'b1;
        check(a_or_n == 1'b1, "R3 chain empty after single word", a_or_n, 1);

        // R4: capacity of N=3 chain
        fill_a(got);
        check(got == TOT_A, "R4 capacity N=3", got, TOT_A);
        check(a_ir_n == 1'b1, "R4 input closed when full", a_ir_n, 1);

        // R7: writes while full are dropped
        got = acc_a;
        for (int i = 0; i < 5; i++) step_a(1'b1, 1'b0, 16'hBEEF);
        a_wen_n = 1'b1;
        check(acc_a == got && a_ir_n, "R7 write while full dropped", acc_a - got, 0);

        // R6: bubble-up latency, N=3
        step_a(1'b0, 1'b1, '0);
        a_ren_n = 1'b1; k = 0;
        while (a_ir_n && k < 100) begin k++; @(posedge clk); #1; end
        check(k == NA-1, "R6 bubble latency N=3", k, NA-1);

        // R2: head word holds while no read
        d0 = a_rd;
        for (int i = 0; i < 4; i++) begin
            step_a(1'b0, 1'b0, '0);
            check(!a_or_n && a_rd == d0, "R2 head stable", int'(a_rd), int'(d0));
        end

        // R9: refill, then gapless drain
        fill_a(got);
        check(got == 1, "R4 refill one slot", got, 1);
        n = 0;
        while (!a_or_n && n < 1000) begin n++; step_a(1'b0, 1'b1, '0); end
        a_ren_n = 1'b1;
        check(n == TOT_A, "R9 consecutive reads", n, TOT_A);
        check(exp_q.size() == 0, "R7 no dropped word surfaced", exp_q.size(), 0);

        // R3: random traffic with varying densities
        for (int ph = 0; ph < 15; ph++) begin
            int pw = 20 + ((ph * 37) % 70);
            int pr = 20 + ((ph * 53) % 70);
            repeat (200) begin
                step_a(($urandom % 100) < pw, ($urandom % 100) < pr, DW'($urandom));
            end
        end
        repeat (8 * TOT_A + 40) step_a(1'b0, 1'b1, '0);
        a_ren_n = 1'b1;
        check(exp_q.size() == 0 && a_or_n, "R3 random traffic fully drained",
              exp_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule